// File: doc/BRIEF.md
# Wake Interrupt Router

This block sits between two groups of interrupt sources and a processor. A group of peripheral wake lines, each with its own output, carries active-high level requests straight through to the processor in peripheral index order. A second group of system-wake lines is merged into one shared interrupt. Each of these lines has its own trigger sense, its own enable bit and its own status bit. A status bit holds an edge until software clears it, or follows the line's level while the line is set to level sense. A wake request output is raised toward power management whenever the system is asleep and any enabled interrupt is pending.

Software reaches the block through a plain single-cycle read/write port. A configuration byte per source number holds the trigger code and the enable. One status byte reports the system-wake lines and is cleared by writing ones. All inputs are asynchronous. Each one passes through a two-flop synchronizer, and edges are found by comparing the current synchronized sample with the one before it.

Top module: `wake_irq_router`

## Requirements
- R1: After reset every enable and trigger code reads 0, every status bit reads 0, and `periphIrq`, `sysIrq` and `wakeReq` are low.
- R2: A write with `addr[4]`=0 configures source number `addr[3:0]`. Sources 0 to 7 are peripheral lines and 8 to 15 are system-wake lines 0 to 7. Data bits [3:0] hold the trigger code and bit 4 holds the enable. A read of the same address returns `{3'b0, enable, code}`. Source numbers beyond the built line counts read 0.
- R3: A peripheral line accepts only active-high level sense. Any code written to it is stored and read back as 4.
- R4: `periphIrq[i]` follows the synchronized peripheral input `i` while its enable is 1, and is 0 while its enable is 0.
- R5: With code 1 (rising edge), a 0-to-1 change on a system-wake line sets its status bit. The bit stays set after the line falls again.
- R6: With code 2 (falling edge), only a 1-to-0 change sets the status bit. With code 3 (both edges), either change sets it.
- R7: With code 4 the status bit equals the live line level. With code 8 it equals the inverted level. Writing a one to clear it has no lasting effect.
- R8: With code 0 (no sense chosen), or with any code other than 1, 2, 3, 4 and 8, the status bit stays 0 whatever the line does.
- R9: A write to address 0x10 clears every edge-sensed status bit whose data bit is 1 and leaves the bits written 0 unchanged. Reading 0x10 returns system-wake line j's status in bit j.
- R10: A line whose enable is 0 still records events in its status bit but does not drive `sysIrq`.
- R11: `sysIrq` is high exactly when some system-wake line has both its status bit and its enable set.
- R12: `wakeReq` is high only while `sleepMode` is 1, and then exactly when some `periphIrq` bit or `sysIrq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| periphIn | input | NUM_PERIPH | Asynchronous peripheral interrupt lines |
| swIn | input | NUM_SYSWAKE | Asynchronous system-wake lines |
| sleepMode | input | 1 | High while the system is powered down |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| periphIrq | output | NUM_PERIPH | Per-peripheral interrupt outputs |
| sysIrq | output | 1 | Shared system-wake interrupt |
| wakeReq | output | 1 | Wake request to power management |

## Verification
The assertions take for granted that a trigger code changes only through a register write. They also take for granted that each input line is held for at least two clock cycles, so that the synchronizer pair shows every change as exactly one edge. The stimulus changes inputs on falling clock edges and holds every level for at least four cycles before it samples. Between scenarios the bench returns every system-wake line to code 0 with its status cleared, so no stale event reaches `sysIrq` in a later check. The same-cycle race between a new edge and a clear is never driven.

// File: rtl/wir_pkg.sv
package wir_pkg;
  localparam int MAX_LINES = 8;

  localparam logic [3:0] TRIG_NONE = 4'd0;
  localparam logic [3:0] TRIG_RISE = 4'd1;
  localparam logic [3:0] TRIG_FALL = 4'd2;
  localparam logic [3:0] TRIG_BOTH = 4'd3;
  localparam logic [3:0] TRIG_HIGH = 4'd4;
  localparam logic [3:0] TRIG_LOW  = 4'd8;

  // Strobes from the register decode to the datapath
  typedef struct packed {
    logic                 clrValid;
    logic [MAX_LINES-1:0] clrMask;
  } ctl_strobe_t;

  function automatic logic isEdgeCode(input logic [3:0] c);
    return (c == TRIG_RISE) || (c == TRIG_FALL) || (c == TRIG_BOTH);
  endfunction

  function automatic logic isLevelCode(input logic [3:0] c);
    return (c == TRIG_HIGH) || (c == TRIG_LOW);
  endfunction
endpackage

// File: rtl/wir_sync.sv
module wir_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/wir_ctrl.sv
module wir_ctrl
  import wir_pkg::*;
#(
  parameter int NUM_PERIPH  = 3,
  parameter int NUM_SYSWAKE = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [4:0]                  addr,
  input  logic [7:0]                  wrData,
  output logic [7:0]                  rdData,
  input  logic [NUM_SYSWAKE-1:0]      swStatus,
  output logic [NUM_PERIPH-1:0]       periphEn,
  output logic [NUM_SYSWAKE-1:0]      swEn,
  output logic [NUM_SYSWAKE-1:0][3:0] swCode,
  output ctl_strobe_t                 stb
);
  localparam logic [4:0] STATUS_ADDR = 5'h10;
  localparam logic [3:0] SW_BASE     = 4'd8;

  logic [NUM_PERIPH-1:0][3:0] periphCode;
  logic [3:0] src;
  logic       cfgWr;

  assign src   = addr[3:0];
  assign cfgWr = wrEn && !addr[4];

  assign stb.clrValid = wrEn && (addr == STATUS_ADDR);
  assign stb.clrMask  = wrData;

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periphCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        periphEn[i]   <= 1'b0;
        periphCode[i] <= TRIG_NONE;
      end else if (cfgWr && src == 4'(i)) begin
        periphEn[i]   <= wrData[4];
        periphCode[i] <= TRIG_HIGH;   // only level-high is legal here
      end
    end

    // R3
    periph_code_chk: assert property (@(posedge clk) disable iff (!rstN)
      (periphCode[i] == TRIG_NONE) || (periphCode[i] == TRIG_HIGH));
  end

  for (genvar j = 0; j < NUM_SYSWAKE; j++) begin : g_swCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        swEn[j]   <= 1'b0;
        swCode[j] <= TRIG_NONE;
      end else if (cfgWr && src == SW_BASE + 4'(j)) begin
        swEn[j]   <= wrData[4];
        swCode[j] <= wrData[3:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (!addr[4]) begin
      for (int i = 0; i < NUM_PERIPH; i++)
        if (src == 4'(i)) rdData = {3'b000, periphEn[i], periphCode[i]};
      for (int j = 0; j < NUM_SYSWAKE; j++)
        if (src == SW_BASE + 4'(j)) rdData = {3'b000, swEn[j], swCode[j]};
    end else if (addr == STATUS_ADDR) begin
      for (int j = 0; j < NUM_SYSWAKE; j++) rdData[j] = swStatus[j];
    end
  end
endmodule

// File: rtl/wir_datapath.sv
module wir_datapath
  import wir_pkg::*;
#(
  parameter int NUM_PERIPH  = 3,
  parameter int NUM_SYSWAKE = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PERIPH-1:0]       periphSync,
  input  logic [NUM_SYSWAKE-1:0]      swSync,
  input  logic [NUM_PERIPH-1:0]       periphEn,
  input  logic [NUM_SYSWAKE-1:0]      swEn,
  input  logic [NUM_SYSWAKE-1:0][3:0] swCode,
  input  ctl_strobe_t                 stb,
  input  logic                        sleepMode,
  output logic [NUM_PERIPH-1:0]       periphIrq,
  output logic [NUM_SYSWAKE-1:0]      swStatus,
  output logic                        sysIrq,
  output logic                        wakeReq
);
  logic [NUM_SYSWAKE-1:0] swPrev;
  logic [NUM_SYSWAKE-1:0] riseVec, fallVec, evtVec, clrVec, statusNext;

  assign riseVec = swSync & ~swPrev;
  assign fallVec = ~swSync & swPrev;
  assign clrVec  = stb.clrValid ? stb.clrMask[NUM_SYSWAKE-1:0] : '0;

  always_comb begin
    for (int j = 0; j < NUM_SYSWAKE; j++) begin
      unique case (swCode[j])
        TRIG_RISE: evtVec[j] = riseVec[j];
        TRIG_FALL: evtVec[j] = fallVec[j];
        TRIG_BOTH: evtVec[j] = riseVec[j] | fallVec[j];
        default:   evtVec[j] = 1'b0;
      endcase
      if (swCode[j] == TRIG_HIGH)      statusNext[j] = swSync[j];
      else if (swCode[j] == TRIG_LOW)  statusNext[j] = ~swSync[j];
      else if (isEdgeCode(swCode[j]))  statusNext[j] = evtVec[j] | (swStatus[j] & ~clrVec[j]);
      else                             statusNext[j] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swPrev   <= '0;
      swStatus <= '0;
    end else begin
      swPrev   <= swSync;
      swStatus <= statusNext;
    end
  end

  assign periphIrq = periphSync & periphEn;
  assign sysIrq    = |(swStatus & swEn);
  assign wakeReq   = sleepMode && ((|periphIrq) || sysIrq);

  // R12
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> sleepMode);

  for (genvar j = 0; j < NUM_SYSWAKE; j++) begin : g_swChk
    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (isEdgeCode(swCode[j]) && swStatus[j] && !clrVec[j])
        |=> (swStatus[j] || !isEdgeCode(swCode[j])));

    // R8
    code_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      swStatus[j] |-> (isEdgeCode($past(swCode[j])) || isLevelCode($past(swCode[j]))));

    // R9
    clear_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      (swCode[j] == TRIG_RISE && clrVec[j] && !riseVec[j]) |=> !swStatus[j]);

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (swEn == '0) |-> !sysIrq);
  end
endmodule

// File: rtl/wake_irq_router.sv
module wake_irq_router
  import wir_pkg::*;
#(
  parameter int NUM_PERIPH  = 3,
  parameter int NUM_SYSWAKE = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PERIPH-1:0]  periphIn,
  input  logic [NUM_SYSWAKE-1:0] swIn,
  input  logic                   sleepMode,
  input  logic                   wrEn,
  input  logic [4:0]             addr,
  input  logic [7:0]             wrData,
  output logic [7:0]             rdData,
  output logic [NUM_PERIPH-1:0]  periphIrq,
  output logic                   sysIrq,
  output logic                   wakeReq
);
  logic [NUM_PERIPH-1:0]       periphSync, periphEn;
  logic [NUM_SYSWAKE-1:0]      swSync, swEn, swStatus;
  logic [NUM_SYSWAKE-1:0][3:0] swCode;
  ctl_strobe_t                 stb;

  initial begin
    assert (NUM_PERIPH >= 1 && NUM_PERIPH <= MAX_LINES);
    assert (NUM_SYSWAKE >= 1 && NUM_SYSWAKE <= MAX_LINES);
  end

  wir_sync #(.WIDTH(NUM_PERIPH)) uPeriphSync (
    .clk(clk), .rstN(rstN), .asyncIn(periphIn), .syncOut(periphSync));

  wir_sync #(.WIDTH(NUM_SYSWAKE)) uSwSync (
    .clk(clk), .rstN(rstN), .asyncIn(swIn), .syncOut(swSync));

  wir_ctrl #(.NUM_PERIPH(NUM_PERIPH), .NUM_SYSWAKE(NUM_SYSWAKE)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .swStatus(swStatus), .periphEn(periphEn),
    .swEn(swEn), .swCode(swCode), .stb(stb));

  wir_datapath #(.NUM_PERIPH(NUM_PERIPH), .NUM_SYSWAKE(NUM_SYSWAKE)) uDatapath (
    .clk(clk), .rstN(rstN), .periphSync(periphSync), .swSync(swSync),
    .periphEn(periphEn), .swEn(swEn), .swCode(swCode), .stb(stb),
    .sleepMode(sleepMode), .periphIrq(periphIrq), .swStatus(swStatus),
    .sysIrq(sysIrq), .wakeReq(wakeReq));
endmodule

// File: tb/tb_wake_irq_router.sv
module tb_wake_irq_router;
  localparam int NP = 3;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] periphIn = '0;
  logic [NS-1:0] swIn = '0;
  logic          sleepMode = 1'b0;
  logic          wrEn = 1'b0;
  logic [4:0]    addr = '0;
  logic [7:0]    wrData = '0;
  logic [7:0]    rdData;
  logic [NP-1:0] periphIrq;
  logic          sysIrq, wakeReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wake_irq_router #(.NUM_PERIPH(NP), .NUM_SYSWAKE(NS)) dut (
    .clk(clk), .rstN(rstN), .periphIn(periphIn), .swIn(swIn),
    .sleepMode(sleepMode), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .periphIrq(periphIrq), .sysIrq(sysIrq), .wakeReq(wakeReq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(logic [4:0] a, logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic regRead(logic [4:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdData;
    addr = '0;
  endtask

  task automatic quietLines();
    for (int j = 0; j < NS; j++) regWrite(5'(8 + j), 8'h00);
    tick(3);
    regWrite(5'h10, 8'hFF);
    tick(1);
  endtask

  task automatic testReset();
    logic [7:0] d;
    chk("R1 periphIrq", 32'(periphIrq), 0);
    chk("R1 sysIrq", 32'(sysIrq), 0);
    chk("R1 wakeReq", 32'(wakeReq), 0);
    regRead(5'd0, d);  chk("R1 periph0 cfg", 32'(d), 0);
    regRead(5'd8, d);  chk("R1 sw0 cfg", 32'(d), 0);
    regRead(5'h10, d); chk("R1 status", 32'(d), 0);
  endtask

  task automatic testConfig();
    logic [7:0] d;
    regWrite(5'd0, 8'h11);
    regRead(5'd0, d);  chk("R3 periph code forced to 4", 32'(d), 32'h14);
    regWrite(5'd1, 8'h08);
    regRead(5'd1, d);  chk("R3 periph1 code 4 enable 0", 32'(d), 32'h04);
    regWrite(5'd9, 8'h13);
    regRead(5'd9, d);  chk("R2 sw1 readback", 32'(d), 32'h13);
    regWrite(5'd3, 8'h11);
    regRead(5'd3, d);  chk("R2 absent periph reads 0", 32'(d), 0);
    regWrite(5'd12, 8'h11);
    regRead(5'd12, d); chk("R2 absent syswake reads 0", 32'(d), 0);
    regWrite(5'd9, 8'h00);
  endtask

  task automatic testPeriph();
    periphIn = 3'b011;
    tick(4);
    chk("R4 enabled periph passes, disabled blocked", 32'(periphIrq), 32'b001);
    periphIn = 3'b000;
    tick(4);
    chk("R4 periph follows level low", 32'(periphIrq), 0);
  endtask

  task automatic testRise();
    logic [7:0] d;
    regWrite(5'd8, 8'h11);
    swIn[0] = 1'b1; tick(4);
    regRead(5'h10, d); chk("R5 rise sets status", 32'(d[0]), 1);
    chk("R11 sysIrq with enabled status", 32'(sysIrq), 1);
    swIn[0] = 1'b0; tick(4);
    regRead(5'h10, d); chk("R5 status sticky after fall", 32'(d[0]), 1);
    regWrite(5'h10, 8'h01); tick(1);
    regRead(5'h10, d); chk("R9 clear edge status", 32'(d[0]), 0);
    chk("R11 sysIrq drops after clear", 32'(sysIrq), 0);
    quietLines();
  endtask

  task automatic testFallBoth();
    logic [7:0] d;
    regWrite(5'd9, 8'h12);
    swIn[1] = 1'b1; tick(4);
    regRead(5'h10, d); chk("R6 falling code ignores rise", 32'(d[1]), 0);
    swIn[1] = 1'b0; tick(4);
    regRead(5'h10, d); chk("R6 falling code sets on fall", 32'(d[1]), 1);
    regWrite(5'd10, 8'h13);
    swIn[2] = 1'b1; tick(4);
    regRead(5'h10, d); chk("R6 both code sets on rise", 32'(d[2]), 1);
    regWrite(5'h10, 8'h04); tick(1);
    regRead(5'h10, d);
    chk("R9 clear bit2 only", 32'(d[2]), 0);
    chk("R9 unwritten bit1 kept", 32'(d[1]), 1);
    swIn[2] = 1'b0; tick(4);
    regRead(5'h10, d); chk("R6 both code sets on fall", 32'(d[2]), 1);
    quietLines();
  endtask

  task automatic testLevel();
    logic [7:0] d;
    regWrite(5'd11, 8'h14);
    swIn[3] = 1'b1; tick(4);
    regRead(5'h10, d); chk("R7 high level status", 32'(d[3]), 1);
    swIn[3] = 1'b0; tick(4);
    regRead(5'h10, d); chk("R7 high level follows low", 32'(d[3]), 0);
    regWrite(5'd11, 8'h18); tick(3);
    regRead(5'h10, d); chk("R7 low level status", 32'(d[3]), 1);
    regWrite(5'h10, 8'h08); tick(1);
    regRead(5'h10, d); chk("R7 level ignores clear", 32'(d[3]), 1);
    swIn[3] = 1'b1; tick(4);
    regRead(5'h10, d); chk("R7 low level follows high", 32'(d[3]), 0);
    swIn[3] = 1'b0;
    quietLines();
  endtask

  task automatic testInvalidCodes();
    logic [7:0] d;
    regWrite(5'd8, 8'h10);
    swIn[0] = 1'b1; tick(4); swIn[0] = 1'b0; tick(4);
    regRead(5'h10, d); chk("R8 code 0 never sets", 32'(d[0]), 0);
    chk("R8 sysIrq quiet on code 0", 32'(sysIrq), 0);
    regWrite(5'd8, 8'h15);
    swIn[0] = 1'b1; tick(4);
    regRead(5'h10, d); chk("R8 code 5 never sets (high)", 32'(d[0]), 0);
    swIn[0] = 1'b0; tick(4);
    regRead(5'h10, d); chk("R8 code 5 never sets (low)", 32'(d[0]), 0);
    quietLines();
  endtask

  task automatic testDisabled();
    logic [7:0] d;
    regWrite(5'd8, 8'h01);
    swIn[0] = 1'b1; tick(4);
    regRead(5'h10, d); chk("R10 disabled line latches", 32'(d[0]), 1);
    chk("R10 disabled line no sysIrq", 32'(sysIrq), 0);
    regWrite(5'd8, 8'h11); tick(1);
    chk("R11 enabling exposes latched status", 32'(sysIrq), 1);
    swIn[0] = 1'b0;
    quietLines();
  endtask

  task automatic testWake();
    periphIn[0] = 1'b1; tick(4);
    chk("R12 no wake while awake", 32'(wakeReq), 0);
    sleepMode = 1'b1; #1;
    chk("R12 wake from periph while asleep", 32'(wakeReq), 1);
    periphIn[0] = 1'b0; tick(4);
    chk("R12 wake drops with no source", 32'(wakeReq), 0);
    regWrite(5'd8, 8'h11);
    swIn[0] = 1'b1; tick(4);
    chk("R12 wake from syswake while asleep", 32'(wakeReq), 1);
    sleepMode = 1'b0; #1;
    chk("R12 wake low once awake", 32'(wakeReq), 0);
    swIn[0] = 1'b0;
    quietLines();
  endtask

  initial begin
    tick(3);
    testReset();
    rstN = 1'b1;
    tick(2);
    testReset();
    testConfig();
    testPeriph();
    testRise();
    testFallBoth();
    testLevel();
    testInvalidCodes();
    testDisabled();
    testWake();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule